// File: doc/BRIEF.md
# Limit Test Grading Bin Controller

This block grades one device per handler cycle. A part handler signals start-of-test on an edge-sensitive strobe. After a fixed settling delay the block asks for measurement points one at a time. Each point arrives with three failure flags: compliance, high limit and low limit. The block then places a three-line bin pattern on the handler port, holds it for a fixed window, and clears it again without any help from outside.

Inside a point the compliance failure ranks first, then the high-limit failure, then the low-limit failure. A point that raises none of the flags passes. Two bin-control policies are available. Under the immediate policy the sweep ends at the first failing point. Under the end-of-sweep policy every programmed point is taken and the first failure seen decides the bin. If no point failed, the pass pattern is shown.

The fourth output line has two uses. In narrow (3-line) mode it is a status line: an end-of-test strobe or a busy flag, in either polarity. In wide mode it follows a level set by software.

Top module: `bin_grader`

## Requirements
- R1: While reset is held and just after it, lines 1-3 are 0 and the measure request is low. Line 4 in narrow mode sits at its deasserted level: 0 for modes 0 and 2, 1 for modes 1 and 3.
- R2: Only the selected edge of the start strobe begins a sweep. A rising edge is used when `arm_rise_i` is 1 and a falling edge when it is 0. The opposite edge does nothing.
- R3: The measure request `meas_go_o` rises exactly SETTLE_CYC cycles after the busy indication rises.
- R4: A point's bin is compliance if `comp_fail_i` is set, otherwise high if `hi_fail_i` is set, otherwise low if `lo_fail_i` is set, otherwise pass.
- R5: When `bin_immediate_i` is 1, the sweep ends at the first point whose bin is not pass, and that bin's pattern is shown. When every point passes, the sweep ends after the last point with the pass pattern.
- R6: When `bin_immediate_i` is 0, all `npoints_i` points are taken. The pattern shown belongs to the earliest failing point, or is the pass pattern if no point failed.
- R7: The bin pattern is held on lines 1-3 for exactly HOLD_CYC cycles. Lines 1-3 then return to 0.
- R8: In narrow mode (`wide_i`=0) line 4 follows `l4_mode_i`. Mode 0 is high during the hold window. Mode 1 is the inverse of mode 0. Mode 2 is high from the accepted start edge until the hold window begins. Mode 3 is the inverse of mode 2.
- R9: In wide mode (`wide_i`=1) line 4 equals `l4_manual_i` at all times.
- R10: A start edge that arrives during settling, measuring or the hold window is ignored, and no second sweep follows.
- R11: A point strobe outside the measuring phase has no effect on the bin or on the point count.
- R12: An `npoints_i` value of 0 behaves as a sweep of one point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sot_i | input | 1 | Start-of-test strobe from the handler (asynchronous) |
| arm_rise_i | input | 1 | 1: rising edge starts a sweep, 0: falling edge |
| wide_i | input | 1 | 1: 4-line mode with a manual line 4, 0: 3-line mode with a status line 4 |
| l4_mode_i | input | 2 | Line 4 status select in 3-line mode (0..3, see R8) |
| l4_manual_i | input | 1 | Line 4 level in 4-line mode |
| bin_immediate_i | input | 1 | 1: stop at the first failure, 0: grade at the end of the sweep |
| npoints_i | input | PT_W | Points per sweep (0 is treated as 1) |
| pass_pat_i | input | 3 | Pattern for a passing device |
| comp_pat_i | input | 3 | Pattern for a compliance failure |
| hi_pat_i | input | 3 | Pattern for a high-limit failure |
| lo_pat_i | input | 3 | Pattern for a low-limit failure |
| pt_valid_i | input | 1 | A point result is present this cycle |
| comp_fail_i | input | 1 | The point failed compliance |
| hi_fail_i | input | 1 | The point is above the high limit |
| lo_fail_i | input | 1 | The point is below the low limit |
| lines_o | output | 4 | Handler lines 1-4 (bit 0 is line 1) |
| meas_go_o | output | 1 | The next point is requested |

## Verification
Several properties are checked on every cycle. The measure request must drop at once after a failing point under the immediate policy, and it must stay up while no point has arrived. Line 4 must agree with the measuring phase in the end-of-test and busy status modes, and it must track the manual level in wide mode. The hold window may never run longer than its programmed length.

Other behaviour can only be shown by the bench scenarios. These cover the priority between flags and between points over every three-point flag combination under both policies, the exact number of points taken, the settling and hold lengths, and the rejection of the wrong start edge. Two further cases are the immunity to stray start edges and stray point strobes, and the zero-point count.

// File: rtl/bin_grader_pkg.sv
package bin_grader_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_MEAS   = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        L4_EOT    = 2'd0,
        L4_EOT_N  = 2'd1,
        L4_BUSY   = 2'd2,
        L4_BUSY_N = 2'd3
    } l4_mode_e;

    typedef enum logic [1:0] {
        BIN_PASS = 2'd0,
        BIN_COMP = 2'd1,
        BIN_HI   = 2'd2,
        BIN_LO   = 2'd3
    } bin_e;

    // Compliance outranks high, high outranks low.
    function automatic bin_e rank_point(input logic comp, input logic hi, input logic lo);
        if (comp)    return BIN_COMP;
        else if (hi) return BIN_HI;
        else if (lo) return BIN_LO;
        else         return BIN_PASS;
    endfunction

    function automatic logic [2:0] pick_pattern(input bin_e b, input logic [2:0] p_pass,
                                                input logic [2:0] p_comp, input logic [2:0] p_hi,
                                                input logic [2:0] p_lo);
        case (b)
            BIN_COMP: return p_comp;
            BIN_HI:   return p_hi;
            BIN_LO:   return p_lo;
            default:  return p_pass;
        endcase
    endfunction

endpackage

// File: rtl/bg_sot_detect.sv
module bg_sot_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sot_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], sot_i};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign edge_o = rise_sel_i ? (sync_q[STAGES-1] & ~prev_q)
                               : (~sync_q[STAGES-1] & prev_q);
endmodule

// File: rtl/bg_rank.sv
module bg_rank
    import bin_grader_pkg::*;
(
    input  logic comp_i,
    input  logic hi_i,
    input  logic lo_i,
    output bin_e bin_o
);
    always_comb bin_o = rank_point(comp_i, hi_i, lo_i);
endmodule

// File: rtl/bg_line_map.sv
module bg_line_map
    import bin_grader_pkg::*;
(
    input  phase_e     phase_i,
    input  logic       wide_i,
    input  logic [1:0] mode_i,
    input  logic       manual_i,
    input  logic [2:0] pat_i,
    output logic [3:0] lines_o
);
    logic busy, eot, l4;

    always_comb begin
        busy = (phase_i == PH_SETTLE) || (phase_i == PH_MEAS);
        eot  = (phase_i == PH_HOLD);
        if (wide_i) begin
            l4 = manual_i;
        end else begin
            case (l4_mode_e'(mode_i))
                L4_EOT:   l4 = eot;
                L4_EOT_N: l4 = ~eot;
                L4_BUSY:  l4 = busy;
                default:  l4 = ~busy;
            endcase
        end
        lines_o = {l4, eot ? pat_i : 3'b000};
    end
endmodule

// File: rtl/bin_grader.sv
module bin_grader
    import bin_grader_pkg::*;
#(
    parameter int PT_W       = 8,
    parameter int SETTLE_CYC = 1000,
    parameter int HOLD_CYC   = 1000,
    parameter int SYNC_STG   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sot_i,
    input  logic            arm_rise_i,
    input  logic            wide_i,
    input  logic [1:0]      l4_mode_i,
    input  logic            l4_manual_i,
    input  logic            bin_immediate_i,
    input  logic [PT_W-1:0] npoints_i,
    input  logic [2:0]      pass_pat_i,
    input  logic [2:0]      comp_pat_i,
    input  logic [2:0]      hi_pat_i,
    input  logic [2:0]      lo_pat_i,
    input  logic            pt_valid_i,
    input  logic            comp_fail_i,
    input  logic            hi_fail_i,
    input  logic            lo_fail_i,
    output logic [3:0]      lines_o,
    output logic            meas_go_o
);
    localparam int MAX_CYC = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int CNT_PW  = PT_W + 1;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_PW-1:0]  pts;
        bin_e               first;
        logic [2:0]         pat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              start_edge;
    bin_e              pt_bin;
    bin_e              first_next;
    logic [CNT_PW-1:0] target;
    logic              last_pt;

    bg_sot_detect #(.STAGES(SYNC_STG)) u_sot (
        .clk        (clk),
        .rst_n      (rst_n),
        .sot_i      (sot_i),
        .rise_sel_i (arm_rise_i),
        .edge_o     (start_edge)
    );

    bg_rank u_rank (
        .comp_i (comp_fail_i),
        .hi_i   (hi_fail_i),
        .lo_i   (lo_fail_i),
        .bin_o  (pt_bin)
    );

    always_comb begin
        target     = (npoints_i == '0) ? CNT_PW'(1) : {1'b0, npoints_i};
        last_pt    = (ctl_q.pts + CNT_PW'(1)) >= target;
        first_next = (ctl_q.first == BIN_PASS) ? pt_bin : ctl_q.first;

        ctl_d = ctl_q;
        case (ctl_q.phase)
            PH_IDLE: begin
                if (start_edge) begin
                    ctl_d.phase = PH_SETTLE;
                    ctl_d.cnt   = '0;
                    ctl_d.pts   = '0;
                    ctl_d.first = BIN_PASS;
                end
            end
            PH_SETTLE: begin
                if (ctl_q.cnt == CNT_W'(SETTLE_CYC - 1)) begin
                    ctl_d.phase = PH_MEAS;
                    ctl_d.cnt   = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
            end
            PH_MEAS: begin
                if (pt_valid_i) begin
                    ctl_d.pts   = ctl_q.pts + CNT_PW'(1);
                    ctl_d.first = first_next;
                    if (last_pt || (bin_immediate_i && (pt_bin != BIN_PASS))) begin
                        ctl_d.phase = PH_HOLD;
                        ctl_d.cnt   = '0;
                        ctl_d.pat   = pick_pattern(first_next, pass_pat_i, comp_pat_i,
                                                   hi_pat_i, lo_pat_i);
                    end
                end
            end
            default: begin
                if (ctl_q.cnt == CNT_W'(HOLD_CYC - 1)) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.cnt   = '0;
                    ctl_d.pat   = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, cnt: '0, pts: '0, first: BIN_PASS, pat: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bg_line_map u_map (
        .phase_i  (ctl_q.phase),
        .wide_i   (wide_i),
        .mode_i   (l4_mode_i),
        .manual_i (l4_manual_i),
        .pat_i    (ctl_q.pat),
        .lines_o  (lines_o)
    );

    assign meas_go_o = (ctl_q.phase == PH_MEAS);
endmodule

// File: rtl/bin_grader_chk.sv
module bin_grader_chk #(
    parameter int HOLD_CYC = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       meas_go,
    input logic       pt_valid,
    input logic       fail_any,
    input logic       imm,
    input logic       wide,
    input logic [1:0] l4_mode,
    input logic       l4_manual,
    input logic       line4,
    input logic       hold
);
    localparam int RUN_W = $clog2(HOLD_CYC + 2);
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            run_q <= '0;
        else if (!hold)                        run_q <= '0;
        else if (run_q != RUN_W'(HOLD_CYC + 1)) run_q <= run_q + RUN_W'(1);
    end

    // R5
    imm_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_go && pt_valid && fail_any && imm) |=> !meas_go);

    // R6
    meas_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_go && !pt_valid) |=> meas_go);

    // R8
    eot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && l4_mode == 2'd0 && meas_go) |-> !line4);

    // R8
    busy_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && l4_mode == 2'd2 && meas_go) |-> line4);

    // R9
    manual_l4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wide |-> (line4 == l4_manual));

    // R7
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (run_q < RUN_W'(HOLD_CYC)));
endmodule

bind bin_grader bin_grader_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .meas_go   (meas_go_o),
    .pt_valid  (pt_valid_i),
    .fail_any  (comp_fail_i | hi_fail_i | lo_fail_i),
    .imm       (bin_immediate_i),
    .wide      (wide_i),
    .l4_mode   (l4_mode_i),
    .l4_manual (l4_manual_i),
    .line4     (lines_o[3]),
    .hold      (ctl_q.phase == bin_grader_pkg::PH_HOLD)
);

// File: tb/bin_grader_test.sv
module bin_grader_test;
    localparam int PT_W   = 3;
    localparam int SETTLE = 4;
    localparam int HOLD   = 5;
    localparam logic [2:0] P_PASS = 3'b001, P_COMP = 3'b010, P_HI = 3'b100, P_LO = 3'b111;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n, sot_i, arm_rise_i, wide_i, l4_manual_i, bin_immediate_i;
    logic [1:0]      l4_mode_i;
    logic [PT_W-1:0] npoints_i;
    logic            pt_valid_i, comp_fail_i, hi_fail_i, lo_fail_i;
    logic [3:0]      lines_o;
    logic            meas_go_o;

    bin_grader #(.PT_W(PT_W), .SETTLE_CYC(SETTLE), .HOLD_CYC(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .sot_i(sot_i), .arm_rise_i(arm_rise_i), .wide_i(wide_i),
        .l4_mode_i(l4_mode_i), .l4_manual_i(l4_manual_i), .bin_immediate_i(bin_immediate_i),
        .npoints_i(npoints_i), .pass_pat_i(P_PASS), .comp_pat_i(P_COMP), .hi_pat_i(P_HI),
        .lo_pat_i(P_LO), .pt_valid_i(pt_valid_i), .comp_fail_i(comp_fail_i),
        .hi_fail_i(hi_fail_i), .lo_fail_i(lo_fail_i), .lines_o(lines_o), .meas_go_o(meas_go_o)
    );

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] pat_of(input int code);
        case (code)
            1: return P_COMP;
            2: return P_HI;
            3: return P_LO;
            default: return P_PASS;
        endcase
    endfunction

    // point bits {comp, hi, lo}
    function automatic int rank_of(input logic [2:0] b);
        if (b[2]) return 1;
        if (b[1]) return 2;
        if (b[0]) return 3;
        return 0;
    endfunction

    function automatic logic l4_level(input int mode, input bit wide, input bit man,
                                      input bit busy, input bit eot);
        if (wide) return man;
        case (mode)
            0: return eot;
            1: return !eot;
            2: return busy;
            default: return !busy;
        endcase
    endfunction

    task automatic sweep(input bit imm, input int npts, input logic [29:0] pbits, input bit noise,
                         input int mode, input bit wide, input bit man, input bit rise);
        int eff, exp_pts, exp_code, k, it, busy_cnt, l4_cnt, code;
        bit restarted;
        logic [2:0] pb;
        @(negedge clk);
        bin_immediate_i = imm; npoints_i = PT_W'(npts); l4_mode_i = 2'(mode);
        wide_i = wide; l4_manual_i = man; arm_rise_i = rise; sot_i = !rise;
        pt_valid_i = 0; comp_fail_i = 0; hi_fail_i = 0; lo_fail_i = 0;
        repeat (4) @(negedge clk);

        eff = (npts == 0) ? 1 : npts;
        exp_pts = 0; exp_code = 0;
        for (int j = 0; j < eff; j++) begin
            code = rank_of(pbits[3*j +: 3]);
            if (exp_code == 0) exp_code = code;
            if (imm && code != 0 && exp_pts == 0) exp_pts = j + 1;
        end
        if (exp_pts == 0) exp_pts = eff;

        sot_i = rise;
        it = 0; busy_cnt = 0;
        while (!meas_go_o && it < 100) begin
            @(negedge clk);
            it++;
            if (it == 2) sot_i = !rise;
            if (!meas_go_o && lines_o[3]) busy_cnt++;
            if (noise && !meas_go_o) begin pt_valid_i = 1; comp_fail_i = 1; end
        end
        sot_i = !rise; pt_valid_i = 0; comp_fail_i = 0;
        chk(meas_go_o, "R2 armed edge starts sweep", int'(meas_go_o), 1);
        if (mode == 2 && !wide) chk(busy_cnt == SETTLE, "R3 settle length", busy_cnt, SETTLE);
        chk(lines_o[3] == l4_level(mode, wide, man, 1, 0), wide ? "R9 line4 measuring" : "R8 line4 measuring",
            int'(lines_o[3]), int'(l4_level(mode, wide, man, 1, 0)));

        if (noise) begin
            sot_i = rise;
            @(negedge clk);
            @(negedge clk);
            sot_i = !rise;
            @(negedge clk);
            chk(meas_go_o, "R10 edge while measuring ignored", int'(meas_go_o), 1);
        end

        k = 0;
        while (meas_go_o && k < 20) begin
            pb = (k < eff) ? pbits[3*k +: 3] : 3'b000;
            pt_valid_i = 1; {comp_fail_i, hi_fail_i, lo_fail_i} = pb;
            k++;
            @(negedge clk);
        end
        pt_valid_i = 0; {comp_fail_i, hi_fail_i, lo_fail_i} = 3'b000;

        if (npts == 0) chk(k == 1, "R12 zero count acts as one", k, 1);
        else chk(k == exp_pts, imm ? "R5 points taken" : "R6 points taken", k, exp_pts);
        chk(lines_o[2:0] == pat_of(exp_code),
            noise ? "R11 bin with stray strobes" : (imm ? "R4 R5 bin pattern" : "R4 R6 bin pattern"),
            int'(lines_o[2:0]), int'(pat_of(exp_code)));
        chk(lines_o[3] == l4_level(mode, wide, man, 0, 1), wide ? "R9 line4 hold" : "R8 line4 hold",
            int'(lines_o[3]), int'(l4_level(mode, wide, man, 0, 1)));

        l4_cnt = int'(lines_o[3]);
        if (noise) begin pt_valid_i = 1; comp_fail_i = 1; sot_i = rise; end
        for (int i = 1; i <= HOLD; i++) begin
            @(negedge clk);
            if (i == 1) sot_i = !rise;
            l4_cnt += int'(lines_o[3]);
        end
        pt_valid_i = 0; comp_fail_i = 0;
        if (mode == 0 && !wide) chk(l4_cnt == HOLD, "R7 hold length", l4_cnt, HOLD);
        chk(lines_o[2:0] == 3'b000, "R7 lines cleared after hold", int'(lines_o[2:0]), 0);

        if (noise) begin
            restarted = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (meas_go_o) restarted = 1;
            end
            chk(!restarted, "R10 no second sweep", int'(restarted), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; sot_i = 0; arm_rise_i = 1; wide_i = 0; l4_mode_i = 2'd0; l4_manual_i = 0;
        bin_immediate_i = 0; npoints_i = '0; pt_valid_i = 0;
        comp_fail_i = 0; hi_fail_i = 0; lo_fail_i = 0;
        repeat (3) @(negedge clk);
        chk(lines_o == 4'b0000, "R1 reset lines mode 0", int'(lines_o), 0);
        chk(!meas_go_o, "R1 reset measure request", int'(meas_go_o), 0);
        l4_mode_i = 2'd1;
        #1 chk(lines_o == 4'b1000, "R1 reset lines mode 1", int'(lines_o), 8);
        l4_mode_i = 2'd3;
        #1 chk(lines_o == 4'b1000, "R1 reset lines mode 3", int'(lines_o), 8);
        @(negedge clk);
        rst_n = 1; l4_mode_i = 2'd2;
        repeat (3) @(negedge clk);
        chk(lines_o == 4'b0000 && !meas_go_o, "R1 after reset release", int'(lines_o), 0);

        // R2: falling edge armed, a rising edge must not start a sweep
        arm_rise_i = 0; sot_i = 1;
        begin
            bit moved = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (meas_go_o || lines_o[3]) moved = 1;
            end
            chk(!moved, "R2 opposite edge ignored", int'(moved), 0);
        end

        sweep(0, 0, 30'd0, 0, 2, 0, 0, 0);
        sweep(0, 6, (30'(3'b001) << 6) | (30'(3'b010) << 9) | (30'(3'b100) << 15), 0, 0, 0, 0, 1);
        sweep(1, 6, (30'(3'b001) << 6) | (30'(3'b010) << 9) | (30'(3'b100) << 15), 1, 2, 0, 0, 0);
        sweep(0, 7, 30'd0, 1, 3, 1, 1, 1);

        for (int s = 0; s < 1024; s++) begin
            sweep(s[9], 3, 30'(s[8:0]), (s % 7) == 0, s % 4, ((s / 4) % 5) == 0,
                  ((s / 8) % 2) == 1, (s % 3) == 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule